// File: doc/BRIEF.md
# Serial Signed Divider

This block divides a signed dividend by a signed, nonzero divisor and produces one quotient bit per clock. A single-cycle `start` pulse, given while the block is idle, captures both operands. The block then runs `WIDTH` non-restoring steps. Each step shifts the partial remainder left, pulling in the next dividend bit. It then subtracts the divisor when the partial remainder and the divisor have the same sign, and adds it otherwise. The new quotient bit shifts in at the bottom of the dividend register. The partial remainder starts as the sign extension of the dividend: all zeros for a non-negative dividend and all ones for a negative one.

Two correction cycles follow the steps. The first negates the quotient when the divisor is negative. The second adds the divisor's magnitude to the remainder when the remainder ended negative. The results are registered together with a one-cycle `done` pulse and held until the next division completes. The quotient and remainder satisfy dividend = quotient × divisor + remainder, with 0 ≤ remainder < |divisor|, and the quotient is taken modulo 2^WIDTH.

Top module: `sdiv_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` and `done` are both low is accepted. `busy` is high from the next cycle for exactly WIDTH+2 cycles.
- R3: `done` is high for exactly one cycle, the cycle right after `busy` falls, and `busy` is low during that cycle.
- R4: A `start` sampled while `busy` or `done` is high is ignored. The running division, its timing and its result are unchanged.
- R5: For a positive divisor d, `quotient` is floor(dividend / d), read as a WIDTH-bit two's complement value.
- R6: For a negative divisor d, `quotient` is the two's complement negation of floor(dividend / |d|), modulo 2^WIDTH.
- R7: `remainder` lies in 0 … |divisor|−1, and dividend = quotient × divisor + remainder holds modulo 2^WIDTH.
- R8: For a negative dividend whose division is not exact, `remainder` is still non-negative, so that, for example, −100 / 7 gives quotient −15 and remainder 5.
- R9: `quotient` and `remainder` change only on the cycle where `done` is high. `dividend` and `divisor` are sampled only on the accepting cycle, so later changes to them have no effect.
- R10: The most negative dividend divided by −1 gives quotient −2^(WIDTH−1) (wrapped) and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted only when idle |
| dividend | input | WIDTH | Signed dividend, sampled on acceptance |
| divisor | input | WIDTH | Signed nonzero divisor, sampled on acceptance |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Signed quotient, held between completions |
| remainder | output | WIDTH | Non-negative remainder, held between completions |

## Verification
Take the edge that samples an accepted `start` as edge zero. `busy` rises after edge zero, and `done` plus both results appear after edge WIDTH+2: WIDTH step edges, then one quotient-fix edge and one remainder-fix edge. The bench keeps its reference model in step with the clock. It models that timing with a countdown rather than with the design's structure, and compares `busy`, `done`, `quotient` and `remainder` against it on the falling edge of every clock. Early, late or missing pulses, and results that change outside the `done` cycle, therefore show up as mismatches. It also pulses `start` during the busy window and during the `done` cycle, and scrambles the operand inputs after acceptance, to show that neither reaches the result.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIXQ,
    ST_FIXR,
    ST_DONE
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_step.sv
// One non-restoring step: shift the remainder/dividend pair left, then add or
// subtract the divisor depending on the sign agreement; the new quotient bit is
// the complement of the resulting remainder sign.
module sdiv_step #(
  parameter int WIDTH = 16,
  localparam int PW = WIDTH + 2
) (
  input  logic [PW-1:0]    rem_i,
  input  logic [WIDTH-1:0] dq_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [PW-1:0]    rem_o,
  output logic [WIDTH-1:0] dq_o
);
  logic [PW-1:0] shl;
  logic [PW-1:0] dext;
  logic          same_sign;

  always_comb begin
    shl       = {rem_i[PW-2:0], dq_i[WIDTH-1]};
    dext      = {{2{dvs_i[WIDTH-1]}}, dvs_i};
    same_sign = (rem_i[PW-1] == dvs_i[WIDTH-1]);
    rem_o     = same_sign ? (shl - dext) : (shl + dext);
    dq_o      = {dq_i[WIDTH-2:0], ~rem_o[PW-1]};
  end
endmodule

// File: rtl/sdiv_fix.sv
// Post-correction datapath: quotient sign fix and remainder restore.
module sdiv_fix #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dq_i,
  input  logic [WIDTH-1:0] rem_low_i,
  input  logic             rem_neg_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] dq_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] mag;

  always_comb begin
    mag   = dvs_i[WIDTH-1] ? (~dvs_i + 1'b1) : dvs_i;
    dq_o  = dvs_i[WIDTH-1] ? (~dq_i + 1'b1) : dq_i;
    rem_o = rem_neg_i ? (rem_low_i + mag) : rem_low_i;
  end
endmodule

// File: rtl/sdiv_ctrl.sv
// Sequencer: idle -> WIDTH steps -> quotient fix -> remainder fix -> done.
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output sdiv_state_e state,
  output logic        busy,
  output logic        done
);
  sdiv_state_e nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_ITER;
      ST_ITER: if (cnt == CW'(1)) nxt = ST_FIXQ;
      ST_FIXQ: nxt = ST_FIXR;
      ST_FIXR: nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      busy  <= (nxt == ST_ITER) || (nxt == ST_FIXQ) || (nxt == ST_FIXR);
      done  <= (nxt == ST_DONE);
      if (state == ST_IDLE && start)
        cnt <= CW'(WIDTH);
      else if (state == ST_ITER)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdiv_seq.sv
module sdiv_seq
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int PW = WIDTH + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  sdiv_state_e      state;
  logic [PW-1:0]    rem_q;
  logic [WIDTH-1:0] dq_q;
  logic [WIDTH-1:0] dvs_q;
  logic [PW-1:0]    step_rem;
  logic [WIDTH-1:0] step_dq;
  logic [WIDTH-1:0] fix_dq;
  logic [WIDTH-1:0] fix_rem;

  sdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .state (state),
    .busy  (busy),
    .done  (done)
  );

  sdiv_step #(.WIDTH(WIDTH)) u_step (
    .rem_i (rem_q),
    .dq_i  (dq_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .dq_o  (step_dq)
  );

  sdiv_fix #(.WIDTH(WIDTH)) u_fix (
    .dq_i      (dq_q),
    .rem_low_i (rem_q[WIDTH-1:0]),
    .rem_neg_i (rem_q[PW-1]),
    .dvs_i     (dvs_q),
    .dq_o      (fix_dq),
    .rem_o     (fix_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      dq_q      <= '0;
      dvs_q     <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          dvs_q <= divisor;
          dq_q  <= dividend;
          rem_q <= {PW{dividend[WIDTH-1]}};
        end
        ST_ITER: begin
          rem_q <= step_rem;
          dq_q  <= step_dq;
        end
        ST_FIXQ: dq_q <= fix_dq;
        ST_FIXR: begin
          quotient  <= dq_q;
          remainder <= fix_rem;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_seq_chk.sv
module sdiv_seq_chk #(
  parameter int WIDTH = 16,
  localparam int BW = $clog2(WIDTH + 8)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  logic [BW-1:0]    bcnt;
  logic [WIDTH-1:0] dv_cap;
  logic [WIDTH:0]   dv_mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt   <= '0;
      dv_cap <= '0;
    end else begin
      bcnt <= busy ? bcnt + 1'b1 : '0;
      if (start && !busy && !done) dv_cap <= divisor;
    end
  end

  assign dv_mag = dv_cap[WIDTH-1] ? ({1'b1, ~dv_cap} + 1'b1) : {1'b0, dv_cap};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!busy && !done && quotient == '0 && remainder == '0)); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done) |=> busy); // R2
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    done |-> (bcnt == BW'(WIDTH + 2))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && !busy)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R4
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    (done && dv_cap != '0) |-> ({1'b0, remainder} < dv_mag)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (quotient != $past(quotient) || remainder != $past(remainder)) |-> done); // R9
endmodule

bind sdiv_seq sdiv_seq_chk #(.WIDTH(WIDTH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/test_sdiv_seq.sv
module test_sdiv_seq;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int n_cmp = 0;
  int n_bad = 0;
  string q_tag = "R5";
  string r_tag = "R7";

  // behavioural reference state
  logic         m_busy = 1'b0;
  logic         m_done = 1'b0;
  logic [W-1:0] m_q = '0;
  logic [W-1:0] m_r = '0;
  logic [W-1:0] p_q = '0;
  logic [W-1:0] p_r = '0;
  int           left = 0;

  always #5 clk = ~clk;

  sdiv_seq #(.WIDTH(W)) i_sdiv_seq (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  function automatic void ref_div(input logic [W-1:0] n_in, input logic [W-1:0] d_in,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
    longint n, d, mag, fl, rr, qq;
    n   = longint'($signed(n_in));
    d   = longint'($signed(d_in));
    mag = (d < 0) ? -d : d;
    if (mag == 0) begin q = '0; r = '0; return; end
    fl = n / mag;
    if ((n % mag) != 0 && n < 0) fl = fl - 1;
    rr = n - fl * mag;
    qq = (d < 0) ? -fl : fl;
    q  = W'(qq);
    r  = W'(rr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_q = '0; m_r = '0; left = 0;
    end else if (!m_busy && !m_done && start) begin
      ref_div(dividend, divisor, p_q, p_r);
      m_busy = 1'b1;
      left   = W + 2;
    end else if (m_busy) begin
      left = left - 1;
      if (left == 0) begin
        m_busy = 1'b0; m_done = 1'b1; m_q = p_q; m_r = p_r;
      end
    end else if (m_done) begin
      m_done = 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "busy", W'(busy), W'(m_busy));
      chk("R3", "done", W'(done), W'(m_done));
      chk(q_tag, "quotient", quotient, m_q);
      chk(r_tag, "remainder", remainder, m_r);
    end
  end

  task automatic run_div(input logic [W-1:0] n, input logic [W-1:0] d,
                         input string qt, input string rt);
    @(negedge clk);
    while (m_busy || m_done) @(negedge clk);
    q_tag = qt; r_tag = rt;
    start = 1'b1; dividend = n; divisor = d;
    @(negedge clk);
    start = 1'b0;
    dividend = W'($urandom);   // R9: operands after acceptance must not matter
    divisor  = W'($urandom);
    repeat (W + 3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy", W'(busy), '0);
    chk("R1", "done", W'(done), '0);
    chk("R1", "quotient", quotient, '0);
    chk("R1", "remainder", remainder, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_div(W'(100),    W'(7),     "R5", "R7");
    run_div(W'(-100),   W'(7),     "R8", "R8");
    run_div(W'(100),    W'(-7),    "R6", "R7");
    run_div(W'(-100),   W'(-7),    "R6", "R8");
    run_div(W'(0),      W'(5),     "R5", "R7");
    run_div(W'(-6),     W'(3),     "R5", "R7");
    run_div(W'(32767),  W'(1),     "R5", "R7");
    run_div(W'(-32768), W'(1),     "R5", "R8");
    run_div(W'(-32768), W'(-1),    "R10", "R10");
    run_div(W'(-32768), W'(-32768), "R6", "R7");
    run_div(W'(5),      W'(-32768), "R6", "R7");
    run_div(W'(-1),     W'(32767), "R8", "R8");

    // R4: start pulses while busy and during the done cycle are ignored
    @(negedge clk);
    while (m_busy || m_done) @(negedge clk);
    q_tag = "R4"; r_tag = "R4";
    start = 1'b1; dividend = W'(1234); divisor = W'(-11);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = W'(9); divisor = W'(2);
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    start = 1'b1; dividend = W'(77); divisor = W'(3);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (b == '0) b = W'(1);
      if (i % 4 == 0) b = W'($signed(b) >>> 9);
      if (b == '0) b = W'(-3);
      run_div(a, b, b[W-1] ? "R6" : "R5", a[W-1] ? "R8" : "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule